// File: doc/BRIEF.md
# Pipelined Signed Lane Prefix Adder

This block takes a batch of eight signed 12-bit lanes packed into one input word and returns, for every lane, the sum of that lane and all lanes below it: an inclusive prefix sum. Each output lane is 15 bits wide, so the running totals cannot wrap. A new batch may enter on every clock. Its result leaves exactly three cycles later, with a valid strobe that marks it.

Inside, the sum is built as a logarithmic adder network. Its three levels combine lanes at distances one, two and four. A register follows each level, and a valid bit moves through the stages next to the data. Reset is synchronous and active high. It empties the pipeline, so any batch still in flight is lost. Whenever no result is due, the output word is held at zero.

Top module: `lane_prefix_adder`

## Requirements
- R1: Input lane k sits in `inData[12k+11:12k]` as a 12-bit two's-complement value. Lane 0 is in the least significant bits.
- R2: Output lane k sits in `outData[15k+14:15k]` as a 15-bit two's-complement value. Lane 0 is in the least significant bits.
- R3: Output lane k equals the exact signed sum of input lanes 0 through k. This holds without wrap at the extremes: eight lanes of -2048 give -16384, and eight lanes of 2047 give 16376.
- R4: A batch taken with `inValid` high in cycle N appears with `outValid` high, carrying its result, in cycle N+3.
- R5: In any cycle where `rst` is high, `outValid` is 0 and `outData` is zero. An `inValid` in such a cycle is ignored and never yields a result.
- R6: A batch still in flight when reset is asserted is discarded, and its result never appears after reset is released.
- R7: In any cycle with no result due, `outValid` is 0 and `outData` is all zeros.
- R8: Batches on consecutive cycles give results on consecutive cycles, each carrying its own sum. Gaps in `inValid` give gaps of the same length in `outValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; flushes the pipeline |
| inValid | input | 1 | Marks the current input word as a batch |
| inData | input | 96 | Eight packed signed 12-bit lanes |
| outValid | output | 1 | Marks a result on `outData` |
| outData | output | 120 | Eight packed signed 15-bit prefix sums; zero when not valid |

## Verification
Several kinds of batch stream back to back through the adder:
- A rising sequence shows that each lane adds only the lanes below it.
- A mixed-sign batch shows that sign extension and borrows are handled.
- A batch that is zero except for its top lane shows that no value spreads downward.
- Alternating extremes, all-maximum and all-minimum batches reach the 15-bit range limits, which a design that keeps too few bits would wrap.

Gaps placed between batches must appear as gaps of the same length at the output. A directed sequence asserts reset while three batches are in flight and a fourth is offered. It shows that none of them reappears, and that a fresh batch afterwards still returns on time.

// File: rtl/lps_pkg.sv
package lps_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic flush;    // clear every stage register this cycle
    logic gateOut;  // final stage holds a result to present
  } lpsCtrl_t;

endpackage

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic [LEVELS-1:0] load,
  output lpsCtrl_t          strobe,
  output logic              outValid
);

  logic [LEVELS-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= (vld << 1) | LEVELS'(inValid);
  end

  // load[s] is high when stage s captures a real batch at the next edge.
  always_comb begin
    load           = (vld << 1) | LEVELS'(inValid);
    strobe.flush   = rst;
    strobe.gateOut = vld[LEVELS-1] & ~rst;
    outValid       = strobe.gateOut;
  end

  // R4 / R8: a result at the last stage implies a batch LEVELS cycles back
  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    vld[LEVELS-1] |-> $past(inValid, LEVELS));

  // R6: the cycle after reset is released, nothing is left in flight
  assert_flush_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (vld == '0));

endmodule

// File: rtl/lps_datapath.sv
module lps_datapath
  import lps_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int IN_W   = 12,
  parameter int OUT_W  = 15,
  parameter int LEVELS = 3
) (
  input  logic                   clk,
  input  logic [LANES*IN_W-1:0]  inData,
  input  logic [LEVELS-1:0]      load,
  input  lpsCtrl_t               strobe,
  output logic [LANES*OUT_W-1:0] outData
);

  localparam int EXT_W = OUT_W - IN_W;

  // net[0] is the sign-extended input, net[l+1] is the register after level l.
  logic [LEVELS:0][LANES-1:0][OUT_W-1:0] net;

  for (genvar k = 0; k < LANES; k++) begin : g_ext
    assign net[0][k] = {{EXT_W{inData[k*IN_W+IN_W-1]}}, inData[k*IN_W +: IN_W]};
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int DIST = 1 << l;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [OUT_W-1:0] sum;
      logic [OUT_W-1:0] q;
      if (k >= DIST) begin : g_add
        assign sum = net[l][k] + net[l][k-DIST];
      end else begin : g_pass
        assign sum = net[l][k];
      end
      always_ff @(posedge clk) begin
        if (strobe.flush || !load[l]) q <= '0;
        else                          q <= sum;
      end
      assign net[l+1][k] = q;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign outData[k*OUT_W +: OUT_W] = strobe.gateOut ? net[LEVELS][k] : '0;
  end

endmodule

// File: rtl/lane_prefix_adder.sv
module lane_prefix_adder
  import lps_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IN_W  = 12,
  parameter int OUT_W = 15
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [LANES*IN_W-1:0]  inData,
  output logic                   outValid,
  output logic [LANES*OUT_W-1:0] outData
);

  localparam int LEVELS = $clog2(LANES);

  logic [LEVELS-1:0] load;
  lpsCtrl_t          strobe;

  lps_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .load     (load),
    .strobe   (strobe),
    .outValid (outValid)
  );

  lps_datapath #(
    .LANES (LANES),
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .LEVELS(LEVELS)
  ) u_dp (
    .clk     (clk),
    .inData  (inData),
    .load    (load),
    .strobe  (strobe),
    .outData (outData)
  );

  function automatic logic signed [OUT_W-1:0] laneTotal(input logic [LANES*IN_W-1:0] d);
    logic signed [OUT_W-1:0] acc;
    logic signed [IN_W-1:0]  ln;
    acc = '0;
    for (int k = 0; k < LANES; k++) begin
      ln  = d[k*IN_W +: IN_W];
      acc = acc + OUT_W'(ln);
    end
    return acc;
  endfunction

  // R1 / R2: lane 0 of the output is lane 0 of the input, sign-extended
  assert_lane0_R1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($signed(outData[OUT_W-1:0]) ==
                  $signed($past(inData[IN_W-1:0], LEVELS))));

  // R3: the top lane carries the full signed total of the batch
  assert_total_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($signed(outData[LANES*OUT_W-1 -: OUT_W]) ==
                  laneTotal($past(inData, LEVELS))));

  // R7: no result means a zero output word
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outData == '0));

  // R5: reset silences the output in the same cycle
  always_comb begin
    if (rst) begin
      assert_reset_quiet_R5: assert (!outValid && outData == '0);
    end
  end

endmodule

// File: tb/sim_lane_prefix_adder.sv
module sim_lane_prefix_adder;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int NV         = 14;

  // Walked table: valid flag and eight lane values per entry.
  localparam bit LVLD [NV] = '{1,1,1,1,0,1,1,1,1,1,0,0,1,1};
  localparam int LANEV [NV][8] = '{
    '{1, 2, 3, 4, 5, 6, 7, 8},
    '{-3, 7, -2, 1, -8, 4, 0, 5},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{2047, -2048, 2047, -2048, 2047, -2048, 2047, -2048},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{5, 5, 5, 5, 5, 5, 5, 5},
    '{-1, -2, -3, -4, -5, -6, -7, -8},
    '{0, 0, 0, 0, 0, 0, 0, 13},
    '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047},
    '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{0, 0, 0, 0, 0, 0, 0, 0},
    '{100, -50, 25, -10, 5, -2, 1, -1},
    '{-2048, 0, 0, 0, 0, 0, 0, 2047}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [95:0]  inData = '0;
  logic         outValid;
  logic [119:0] outData;

  int total = 0;
  int fails = 0;

  logic         expV [NV + LAT];
  logic [119:0] expD [NV + LAT];

  lane_prefix_adder u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [95:0] packRow(input int r);
    logic [95:0] p = '0;
    for (int k = 0; k < 8; k++) begin
      p[k*12 +: 12] = LANEV[r][k][11:0];
    end
    return p;
  endfunction

  // R3: expected inclusive sums, R2: 15-bit lanes with lane 0 lowest
  function automatic logic [119:0] scanRow(input int r);
    logic [119:0] p = '0;
    int run = 0;
    for (int k = 0; k < 8; k++) begin
      run = run + LANEV[r][k];
      p[k*15 +: 15] = run[14:0];
    end
    return p;
  endfunction

  task automatic check(input string req, input logic av, input logic [119:0] ad,
                       input logic ev, input logic [119:0] ed);
    total++;
    if (av !== ev || ad !== ed) begin
      fails++;
      $display("FAIL %s actual valid=%0b data=%h expected valid=%0b data=%h",
               req, av, ad, ev, ed);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    total++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // Reset state, with a valid batch offered during reset (R5)
    repeat (2) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = packRow(12);
      #1 check("R5 reset state", outValid, outData, 1'b0, '0);
    end
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    inData = '0;
    for (int c = 0; c < LAT + 1; c++) begin
      @(negedge clk);
      check("R5 batch offered in reset ignored", outValid, outData, 1'b0, '0);
    end

    // Table walk: back-to-back batches with bubbles (R1 R2 R3 R4 R7 R8)
    for (int c = 0; c < NV; c++) begin
      expV[c + LAT] = LVLD[c];
      expD[c + LAT] = LVLD[c] ? scanRow(c) : '0;
    end
    for (int c = 0; c < LAT; c++) begin
      expV[c] = 1'b0;
      expD[c] = '0;
    end
    for (int c = 0; c < NV + LAT; c++) begin
      @(negedge clk);
      check(c < LAT ? "R7 idle before first result" : "R3 R4 R8 table result",
            outValid, outData, expV[c], expD[c]);
      if (c < NV) begin
        inValid = LVLD[c];
        inData  = packRow(c);
      end else begin
        inValid = 1'b0;
        inData  = packRow(3);
      end
    end
    @(negedge clk);
    check("R7 idle after stream", outValid, outData, 1'b0, '0);

    // Reset while three batches are in flight and a fourth is offered
    @(negedge clk); inValid = 1'b1; inData = packRow(0);
    @(negedge clk); inValid = 1'b1; inData = packRow(5);
    @(negedge clk); inValid = 1'b1; inData = packRow(6);
    @(negedge clk); inValid = 1'b1; inData = packRow(12); rst = 1'b1;
    #1 check("R5 result due in reset cycle suppressed", outValid, outData, 1'b0, '0);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    inData = '0;
    for (int c = 0; c < LAT + 1; c++) begin
      check("R6 in-flight batch dropped", outValid, outData, 1'b0, '0);
      @(negedge clk);
    end

    // Fresh batch after the flush returns on time (R4)
    inValid = 1'b1;
    inData  = packRow(1);
    @(negedge clk);
    inValid = 1'b0;
    inData  = '0;
    @(negedge clk);
    check("R4 no early result", outValid, outData, 1'b0, '0);
    @(negedge clk);
    check("R4 result at N+3", outValid, outData, 1'b1, scanRow(1));
    @(negedge clk);
    check("R7 single result only", outValid, outData, 1'b0, '0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule